// File: doc/BRIEF.md
# I2C RTC Transaction Monitor

This block watches a stream of I2C bus events that have already been decoded and rebuilds the register traffic of a real-time-clock slave from it. Each event arrives as a one-cycle strobe carrying a kind code and a byte. The monitor follows the usual access pattern. A START is followed by a write-addressed frame, and the first data byte of that frame sets a register pointer. Further data bytes are writes at that pointer, which advances by one after each byte. A repeated START followed by a read-addressed frame turns the access into a read from the same pointer.

For each register byte seen, the monitor emits a one-cycle report. The report carries the register index, the data, the direction, and whether the index falls in the clock/control group or in the battery-backed RAM group. At STOP it emits a one-cycle end-of-burst pulse tagged read or write and advances a running burst counter. It drives nothing on the bus and is meant for protocol checking and trace capture next to an I2C controller.

Top module: `i2c_rtc_monitor`

## Requirements
- R1: Event kind codes on `ev_kind` are START=0, repeated START=1, address-write=2, address-read=3, data-write=4, data-read=5 and STOP=6. While idle, every event other than START is ignored: no report, no end pulse, and the monitor stays idle.
- R2: After START, a write-address event for the device address moves the monitor to wait for the pointer. The address is in `ev_byte[6:0]` and defaults to 0x68. The next data-write byte loads the pointer from its low 6 bits and produces no report.
- R3: After the pointer is loaded, each data-write byte produces a report one cycle later with `acc_valid`=1, `acc_is_read`=0, `acc_index` set to the current pointer and `acc_data` set to the byte. The pointer then increments by one.
- R4: A repeated START after the pointer is loaded makes the monitor wait for a read-address event for the device address. Each following data-read byte is then reported with `acc_is_read`=1 at the current pointer, which then increments by one.
- R5: STOP in the write or read burst state gives a one-cycle `burst_done` pulse with `burst_is_read` set to 0 for write or 1 for read. It increments `burst_count` by one and returns the monitor to idle.
- R6: `acc_is_ram` is 0 for indices 0 to 7 (clock/control) and 1 for indices 0x08 to 0x3F (RAM).
- R7: The pointer wraps from 0x3F to 0x00 on increment.
- R8: A START or repeated START in any non-idle state restarts the sequence at the write-address wait. The only exception is a repeated START during a write burst, which behaves as R4 describes.
- R9: An address event (write or read) whose address differs from the device address returns the monitor to idle. A STOP outside a burst returns it to idle without an end pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | One-cycle strobe marking a bus event |
| ev_kind | input | 3 | Event kind code |
| ev_byte | input | 8 | Address or data byte of the event |
| acc_valid | output | 1 | One-cycle register access report |
| acc_is_read | output | 1 | Reported access is a read |
| acc_index | output | 6 | Register index of the access |
| acc_data | output | 8 | Data byte of the access |
| acc_is_ram | output | 1 | Index is in the RAM group |
| burst_done | output | 1 | One-cycle end-of-burst pulse |
| burst_is_read | output | 1 | Finished burst was a read |
| burst_count | output | 16 | Number of bursts finished since reset |

## Verification
The assertions assume that events arrive as single-cycle strobes with a legal kind code, and that every burst is bracketed by START and STOP in the order a real bus produces. Under that assumption a repeated STOP reaches an idle monitor and cannot pulse twice. The directed stimulus keeps to this: it sends one event per strobe, leaves an empty cycle between events, and sends out-of-order events only to probe the ignore and restart rules. The expected pointer, RAM flag and burst count are tracked in the bench from the bytes it sends.

// File: rtl/rtcmon_pkg.sv
package rtcmon_pkg;

    typedef enum logic [2:0] {
        EV_START   = 3'd0,
        EV_RSTART  = 3'd1,
        EV_ADDR_WR = 3'd2,
        EV_ADDR_RD = 3'd3,
        EV_DATA_WR = 3'd4,
        EV_DATA_RD = 3'd5,
        EV_STOP    = 3'd6
    } ev_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_AW,
        ST_WAIT_PTR,
        ST_WR_BURST,
        ST_WAIT_AR,
        ST_RD_BURST
    } mon_state_e;

endpackage

// File: rtl/rtcmon_fsm.sv
module rtcmon_fsm
    import rtcmon_pkg::*;
#(
    parameter int          PTR_W    = 6,
    parameter logic [6:0]  DEV_ADDR = 7'h68
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  logic [2:0]       ev_kind,
    input  logic [7:0]       ev_byte,
    output logic             acc_fire,
    output logic             acc_read,
    output logic [PTR_W-1:0] acc_idx,
    output logic [7:0]       acc_byte,
    output logic             end_fire,
    output logic             end_read
);

    typedef struct packed {
        mon_state_e       st;
        logic [PTR_W-1:0] ptr;
    } fsm_t;

    fsm_t     fsm_d, fsm_q;
    ev_kind_e kind;
    logic     addr_hit;

    assign kind     = ev_kind_e'(ev_kind);
    assign addr_hit = (ev_byte[6:0] == DEV_ADDR);

    always_comb begin
        fsm_d    = fsm_q;
        acc_fire = 1'b0;
        acc_read = 1'b0;
        acc_idx  = fsm_q.ptr;
        acc_byte = ev_byte;
        end_fire = 1'b0;
        end_read = 1'b0;
        if (ev_valid) begin
            if (fsm_q.st == ST_IDLE) begin
                if (kind == EV_START) fsm_d.st = ST_WAIT_AW;
            end else begin
                case (kind)
                    EV_START:  fsm_d.st = ST_WAIT_AW;
                    EV_RSTART: fsm_d.st = (fsm_q.st == ST_WR_BURST) ? ST_WAIT_AR : ST_WAIT_AW;
                    EV_STOP: begin
                        fsm_d.st = ST_IDLE;
                        end_fire = (fsm_q.st == ST_WR_BURST) || (fsm_q.st == ST_RD_BURST);
                        end_read = (fsm_q.st == ST_RD_BURST);
                    end
                    EV_ADDR_WR: begin
                        if (!addr_hit)                   fsm_d.st = ST_IDLE;
                        else if (fsm_q.st == ST_WAIT_AW) fsm_d.st = ST_WAIT_PTR;
                    end
                    EV_ADDR_RD: begin
                        if (!addr_hit)                   fsm_d.st = ST_IDLE;
                        else if (fsm_q.st == ST_WAIT_AR) fsm_d.st = ST_RD_BURST;
                    end
                    EV_DATA_WR: begin
                        if (fsm_q.st == ST_WAIT_PTR) begin
                            fsm_d.ptr = ev_byte[PTR_W-1:0];
                            fsm_d.st  = ST_WR_BURST;
                        end else if (fsm_q.st == ST_WR_BURST) begin
                            acc_fire  = 1'b1;
                            fsm_d.ptr = fsm_q.ptr + 1'b1;
                        end
                    end
                    EV_DATA_RD: begin
                        if (fsm_q.st == ST_RD_BURST) begin
                            acc_fire  = 1'b1;
                            acc_read  = 1'b1;
                            fsm_d.ptr = fsm_q.ptr + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q.st  <= ST_IDLE;
            fsm_q.ptr <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_IDLE && !(ev_valid && kind == EV_START)) |=> fsm_q.st == ST_IDLE);

    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && kind == EV_DATA_WR && fsm_q.st == ST_WR_BURST)
            |=> fsm_q.ptr == PTR_W'($past(fsm_q.ptr) + 1'b1));

    assert_rd_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsm_q.st == ST_RD_BURST) |-> $past(fsm_q.st) == ST_WAIT_AR);

    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && kind == EV_START && fsm_q.st != ST_IDLE) |=> fsm_q.st == ST_WAIT_AW);

endmodule

// File: rtl/rtcmon_class.sv
module rtcmon_class #(
    parameter int PTR_W     = 6,
    parameter int CTRL_REGS = 8
) (
    input  logic [PTR_W-1:0] idx,
    output logic             is_ram
);

    localparam logic [PTR_W-1:0] CTRL_LIM = PTR_W'(CTRL_REGS);

    generate
        if (CTRL_REGS <= 0) begin : g_all_ram
            assign is_ram = 1'b1;
        end else begin : g_split
            assign is_ram = (idx >= CTRL_LIM);
        end
    endgenerate

endmodule

// File: rtl/rtcmon_report.sv
module rtcmon_report #(
    parameter int PTR_W     = 6,
    parameter int CNT_W     = 16,
    parameter int CTRL_REGS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_fire,
    input  logic             acc_read,
    input  logic [PTR_W-1:0] acc_idx,
    input  logic [7:0]       acc_byte,
    input  logic             acc_ram,
    input  logic             end_fire,
    input  logic             end_read,
    output logic             acc_valid,
    output logic             acc_is_read,
    output logic [PTR_W-1:0] acc_index,
    output logic [7:0]       acc_data,
    output logic             acc_is_ram,
    output logic             burst_done,
    output logic             burst_is_read,
    output logic [CNT_W-1:0] burst_count
);

    localparam logic [PTR_W-1:0] CTRL_LIM = PTR_W'(CTRL_REGS);

    typedef struct packed {
        logic             valid;
        logic             rd;
        logic [PTR_W-1:0] idx;
        logic [7:0]       data;
        logic             ram;
        logic             done;
        logic             done_rd;
        logic [CNT_W-1:0] cnt;
    } rep_t;

    rep_t rep_d, rep_q;

    always_comb begin
        rep_d         = rep_q;
        rep_d.valid   = acc_fire;
        rep_d.done    = end_fire;
        if (acc_fire) begin
            rep_d.rd   = acc_read;
            rep_d.idx  = acc_idx;
            rep_d.data = acc_byte;
            rep_d.ram  = acc_ram;
        end
        if (end_fire) begin
            rep_d.done_rd = end_read;
            rep_d.cnt     = rep_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rep_q <= '0;
        end else begin
            rep_q <= rep_d;
        end
    end

    assign acc_valid     = rep_q.valid;
    assign acc_is_read   = rep_q.rd;
    assign acc_index     = rep_q.idx;
    assign acc_data      = rep_q.data;
    assign acc_is_ram    = rep_q.ram;
    assign burst_done    = rep_q.done;
    assign burst_is_read = rep_q.done_rd;
    assign burst_count   = rep_q.cnt;

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> !burst_done);

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> burst_count == CNT_W'($past(burst_count) + 1'b1));

    assert_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> (acc_is_ram == (acc_index >= CTRL_LIM)));

endmodule

// File: rtl/i2c_rtc_monitor.sv
module i2c_rtc_monitor #(
    parameter int          PTR_W     = 6,
    parameter int          CNT_W     = 16,
    parameter int          CTRL_REGS = 8,
    parameter logic [6:0]  DEV_ADDR  = 7'h68
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  logic [2:0]       ev_kind,
    input  logic [7:0]       ev_byte,
    output logic             acc_valid,
    output logic             acc_is_read,
    output logic [PTR_W-1:0] acc_index,
    output logic [7:0]       acc_data,
    output logic             acc_is_ram,
    output logic             burst_done,
    output logic             burst_is_read,
    output logic [CNT_W-1:0] burst_count
);

    logic             fire, fire_rd, stop_fire, stop_rd, ram_flag;
    logic [PTR_W-1:0] idx;
    logic [7:0]       dbyte;

    rtcmon_fsm #(.PTR_W(PTR_W), .DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_valid (ev_valid),
        .ev_kind  (ev_kind),
        .ev_byte  (ev_byte),
        .acc_fire (fire),
        .acc_read (fire_rd),
        .acc_idx  (idx),
        .acc_byte (dbyte),
        .end_fire (stop_fire),
        .end_read (stop_rd)
    );

    rtcmon_class #(.PTR_W(PTR_W), .CTRL_REGS(CTRL_REGS)) u_class (
        .idx    (idx),
        .is_ram (ram_flag)
    );

    rtcmon_report #(.PTR_W(PTR_W), .CNT_W(CNT_W), .CTRL_REGS(CTRL_REGS)) u_report (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_fire      (fire),
        .acc_read      (fire_rd),
        .acc_idx       (idx),
        .acc_byte      (dbyte),
        .acc_ram       (ram_flag),
        .end_fire      (stop_fire),
        .end_read      (stop_rd),
        .acc_valid     (acc_valid),
        .acc_is_read   (acc_is_read),
        .acc_index     (acc_index),
        .acc_data      (acc_data),
        .acc_is_ram    (acc_is_ram),
        .burst_done    (burst_done),
        .burst_is_read (burst_is_read),
        .burst_count   (burst_count)
    );

endmodule

// File: tb/i2c_rtc_monitor_test.sv
module i2c_rtc_monitor_test;

    localparam logic [2:0] K_START = 3'd0, K_RSTART = 3'd1, K_AW = 3'd2, K_AR = 3'd3,
                           K_DW = 3'd4, K_DR = 3'd5, K_STOP = 3'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic [2:0]  ev_kind = 3'd0;
    logic [7:0]  ev_byte = 8'd0;
    logic        acc_valid, acc_is_read, acc_is_ram, burst_done, burst_is_read;
    logic [5:0]  acc_index;
    logic [7:0]  acc_data;
    logic [15:0] burst_count;

    int n_checks = 0;
    int n_fails  = 0;
    int exp_cnt  = 0;

    always #10 clk = ~clk;

    i2c_rtc_monitor uut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_byte(ev_byte),
        .acc_valid(acc_valid), .acc_is_read(acc_is_read), .acc_index(acc_index),
        .acc_data(acc_data), .acc_is_ram(acc_is_ram), .burst_done(burst_done),
        .burst_is_read(burst_is_read), .burst_count(burst_count)
    );

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send(logic [2:0] k, logic [7:0] b);
        @(negedge clk);
        ev_valid = 1'b1; ev_kind = k; ev_byte = b;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic expect_none(string req);
        check(req, "acc_valid", int'(acc_valid), 0);
        check(req, "burst_done", int'(burst_done), 0);
    endtask

    task automatic expect_acc(string req, bit rd, int idx, int data);
        check(req, "acc_valid", int'(acc_valid), 1);
        check(req, "acc_is_read", int'(acc_is_read), int'(rd));
        check(req, "acc_index", int'(acc_index), idx);
        check(req, "acc_data", int'(acc_data), data);
        check("R6", "acc_is_ram", int'(acc_is_ram), (idx >= 8) ? 1 : 0);
    endtask

    task automatic expect_done(string req, bit rd);
        exp_cnt++;
        check(req, "burst_done", int'(burst_done), 1);
        check(req, "burst_is_read", int'(burst_is_read), int'(rd));
        check(req, "burst_count", int'(burst_count), exp_cnt);
    endtask

    task automatic t_reset;
        check("R5", "reset burst_count", int'(burst_count), 0);
        expect_none("R1");
    endtask

    task automatic t_idle_ignore;
        send(K_DW, 8'h12);   expect_none("R1");
        send(K_STOP, 8'h00); expect_none("R1");
        send(K_AW, 8'h68);   expect_none("R1");
        send(K_RSTART, 8'h00); expect_none("R1");
        send(K_DW, 8'h13);   expect_none("R1");
        send(K_DR, 8'h14);   expect_none("R1");
        check("R5", "count after ignored STOP", int'(burst_count), exp_cnt);
    endtask

    task automatic t_write_burst;
        send(K_START, 8'h00); expect_none("R2");
        send(K_AW, 8'h68);    expect_none("R2");
        send(K_DW, 8'h05);    expect_none("R2");
        send(K_DW, 8'hAA);    expect_acc("R3", 1'b0, 5, 8'hAA);
        send(K_DW, 8'h55);    expect_acc("R3", 1'b0, 6, 8'h55);
        send(K_STOP, 8'h00);  expect_done("R5", 1'b0);
        send(K_DW, 8'h77);    expect_none("R5");
    endtask

    task automatic t_class_edge;
        send(K_START, 8'h00); send(K_AW, 8'h68);
        send(K_DW, 8'hC7);    expect_none("R2");
        send(K_DW, 8'h01);    expect_acc("R6", 1'b0, 7, 8'h01);
        send(K_DW, 8'h02);    expect_acc("R6", 1'b0, 8, 8'h02);
        send(K_STOP, 8'h00);  expect_done("R5", 1'b0);
    endtask

    task automatic t_wrap;
        send(K_START, 8'h00); send(K_AW, 8'h68); send(K_DW, 8'h3E);
        send(K_DW, 8'hE0);    expect_acc("R7", 1'b0, 62, 8'hE0);
        send(K_DW, 8'hE1);    expect_acc("R7", 1'b0, 63, 8'hE1);
        send(K_DW, 8'hE2);    expect_acc("R7", 1'b0, 0, 8'hE2);
        send(K_STOP, 8'h00);  expect_done("R5", 1'b0);
    endtask

    task automatic t_read_burst;
        send(K_START, 8'h00); send(K_AW, 8'h68); send(K_DW, 8'h10);
        send(K_RSTART, 8'h00); expect_none("R4");
        send(K_DR, 8'h99);    expect_none("R4");
        send(K_AR, 8'h68);    expect_none("R4");
        send(K_DR, 8'h31);    expect_acc("R4", 1'b1, 16, 8'h31);
        send(K_DR, 8'h32);    expect_acc("R4", 1'b1, 17, 8'h32);
        send(K_DW, 8'h33);    expect_none("R4");
        send(K_STOP, 8'h00);  expect_done("R5", 1'b1);
        send(K_START, 8'h00); send(K_AW, 8'h68); send(K_DW, 8'h3F);
        send(K_RSTART, 8'h00); send(K_AR, 8'h68);
        send(K_DR, 8'h40);    expect_acc("R7", 1'b1, 63, 8'h40);
        send(K_DR, 8'h41);    expect_acc("R7", 1'b1, 0, 8'h41);
        send(K_STOP, 8'h00);  expect_done("R5", 1'b1);
    endtask

    task automatic t_restart;
        send(K_START, 8'h00); send(K_AW, 8'h68);
        send(K_START, 8'h00); expect_none("R8");
        send(K_AW, 8'h68); send(K_DW, 8'h02);
        send(K_DW, 8'h5A);    expect_acc("R8", 1'b0, 2, 8'h5A);
        send(K_START, 8'h00); expect_none("R8");
        send(K_DW, 8'h5B);    expect_none("R8");
        send(K_AW, 8'h68); send(K_DW, 8'h20); send(K_RSTART, 8'h00); send(K_AR, 8'h68);
        send(K_RSTART, 8'h00); expect_none("R8");
        send(K_DR, 8'h11);    expect_none("R8");
        send(K_STOP, 8'h00);  expect_none("R8");
        check("R8", "count unchanged", int'(burst_count), exp_cnt);
    endtask

    task automatic t_addr_mismatch;
        send(K_START, 8'h00);
        send(K_AW, 8'h50);    expect_none("R9");
        send(K_AW, 8'h68);    expect_none("R9");
        send(K_DW, 8'h04);    expect_none("R9");
        send(K_DW, 8'h05);    expect_none("R9");
        send(K_START, 8'h00); send(K_AW, 8'h68); send(K_DW, 8'h03);
        send(K_RSTART, 8'h00);
        send(K_AR, 8'h51);    expect_none("R9");
        send(K_DR, 8'h66);    expect_none("R9");
        send(K_STOP, 8'h00);  expect_none("R9");
        check("R9", "count unchanged", int'(burst_count), exp_cnt);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_idle_ignore;
        t_write_burst;
        t_class_edge;
        t_wrap;
        t_read_burst;
        t_restart;
        t_addr_mismatch;
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #4000000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule